// File: doc/BRIEF.md
# Two-Stage Cascaded Noise-Shaping Modulator

This block is the digital core of an oversampled audio DAC. It takes one interpolated signed PCM sample per modulator clock, when a valid strobe is high, and turns it into two coarse 33-level codes.

The first loop shapes the input signal itself. The block then takes the difference between the input and the first code, multiplies it by a power-of-two gain K, and feeds it to a second loop of the same kind. Each code drives its own element DAC, and the analog side weights the second DAC by 1/K. In that sum the error of the first loop cancels. What remains is the second loop's shaped error, divided by K.

Both loops use a second-order error-feedback structure with noise transfer function (1 − z⁻¹)². All arithmetic is signed fixed point with saturation. One code step equals 2^(DATA_W−1)/HALF_LEVELS input units, which is 2048 with the defaults.

Top module: `csd_cascade`

## Requirements
- R1: A synchronous active-low reset clears both loops' error states and the pipeline registers. While reset is held, `out_valid` is 0 and both codes are 0.
- R2: Both codes are two's-complement values. They always lie in −HALF_LEVELS..+HALF_LEVELS, which is −16..+16 in a 6-bit field with the defaults.
- R3: For each accepted sample x, the primary loop forms v = sat18(x − 2·qa + qb). Its code is c = clamp±16(floor((v + 1024)/2048)). The new error is q = clamp±4096(c·2048 − v), and it shifts into the state (qb ← qa, qa ← q). Here sat18 saturates v to the signed 18-bit range.
- R4: The secondary input is r = sat16(4·(x − c_p·2048)), where c_p is the primary code for the same sample, K = 4, and sat16 saturates to the signed 16-bit range.
- R5: The secondary loop applies the R3 recursion to r, using its own states, and produces c_s.
- R6: `out_valid` rises exactly two clock cycles after the edge that accepts a sample. `code_p` and `code_s` then show the primary and secondary codes of that same sample.
- R7: While no sample is accepted, both loop states hold. The output codes also hold for every cycle in which `out_valid` is low.
- R8: For inputs with |x| ≤ 24576, the recombined error obeys |K·(c_p·2048 − x) + c_s·2048| ≤ 4096. That is, only the secondary error shaped by (1 − z⁻¹)² remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample is present on `in_data` this cycle |
| in_data | input | DATA_W (16) | Signed PCM sample |
| out_valid | output | 1 | Codes belong to a new sample |
| code_p | output | CODE_W (6) | Primary loop code, signed |
| code_s | output | CODE_W (6) | Secondary loop code, to be weighted by 1/K |

## Verification
The bench builds the block with its defaults: a 16-bit input, 33 levels and K = 4. These values make the step size 2048, so a DC input lands exactly on, or between, code boundaries that can be predicted by hand.

K = 4 keeps the gained-up primary error inside the secondary loop's full scale. This brings the cancellation bound of R8 within reach on every sample of a slow triangle sweep. The same settings let full-scale inputs drive both ends of the code range. Gaps in the valid strobe and a mid-run reset show the state holding and clearing.

// File: rtl/csd_pkg.sv
// Package: shared saturation helpers for the cascaded modulator.
// Assumes all operands are already sign-extended to the width handled.
package csd_pkg;

    // Saturate a 32-bit signed value into [lo, hi].
    function automatic logic signed [31:0] clamp32(input logic signed [31:0] v,
                                                   input logic signed [31:0] lo,
                                                   input logic signed [31:0] hi);
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/csd_quant.sv
// Module: multi-level mid-tread quantizer.
// Rounds the loop value to the nearest code step (ties upward) and clamps the code
// to +/-HALF_LEVELS. Also returns the quantization error (code*step - v), clamped
// to +/- two steps so that the loop state stays bounded on overload.
// Assumes STEP_SH >= 1 and ACC_W large enough to hold HALF_LEVELS steps.
module csd_quant #(
    parameter int ACC_W       = 18,
    parameter int STEP_SH     = 11,
    parameter int HALF_LEVELS = 16,
    parameter int CODE_W      = 6
) (
    input  logic signed [ACC_W-1:0]  v,
    output logic signed [CODE_W-1:0] code,
    output logic signed [ACC_W-1:0]  qerr
);
    import csd_pkg::*;

    localparam logic signed [31:0] HALF_STEP = 32'sd1 <<< (STEP_SH - 1);
    localparam logic signed [31:0] ERR_LIM   = 32'sd2 <<< STEP_SH;

    logic signed [31:0] v_w, lvl, rec;

    // Rounds to the nearest step, clamps the code and derives the error.
    always_comb begin
        v_w  = 32'(v);
        lvl  = clamp32((v_w + HALF_STEP) >>> STEP_SH,
                       -32'(HALF_LEVELS), 32'(HALF_LEVELS));
        rec  = lvl <<< STEP_SH;
        code = CODE_W'(lvl);
        qerr = ACC_W'(clamp32(rec - v_w, -ERR_LIM, ERR_LIM));
    end
endmodule

// File: rtl/csd_shaper.sv
// Module: second-order error-feedback noise shaper, NTF = (1 - z^-1)^2.
// The code is combinational from the present input and the two stored errors.
// The error states advance only on edges where 'en' is high. The loop sum
// saturates to ACC_W bits. Assumes DATA_W < ACC_W.
module csd_shaper #(
    parameter int DATA_W      = 16,
    parameter int ACC_W       = 18,
    parameter int STEP_SH     = 11,
    parameter int HALF_LEVELS = 16,
    parameter int CODE_W      = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [CODE_W-1:0] code
);
    import csd_pkg::*;

    localparam logic signed [31:0] ACC_MAX = (32'sd1 <<< (ACC_W - 1)) - 32'sd1;

    logic signed [ACC_W-1:0] qa, qb, v, qnew;

    // Loop sum: input minus twice the last error plus the one before, saturated.
    always_comb begin
        v = ACC_W'(clamp32(32'(x) - (32'(qa) <<< 1) + 32'(qb), -ACC_MAX, ACC_MAX));
    end

    csd_quant #(
        .ACC_W(ACC_W), .STEP_SH(STEP_SH),
        .HALF_LEVELS(HALF_LEVELS), .CODE_W(CODE_W)
    ) i_quant (
        .v(v), .code(code), .qerr(qnew)
    );

    // Error delay line: cleared on reset, shifted on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qa <= '0;
            qb <= '0;
        end else if (en) begin
            qa <= qnew;
            qb <= qa;
        end
    end
endmodule

// File: rtl/csd_cascade.sv
// Module: two-stage cascaded modulator top.
// Stage one shapes the input. The difference between the input and its code,
// gained by 2^K_SHIFT, is registered and shaped by stage two on the next cycle.
// Both codes leave through an aligned output register, two cycles after the
// sample is accepted. Assumes HALF_LEVELS is a power of two below 2^(DATA_W-2).
module csd_cascade #(
    parameter int DATA_W      = 16,
    parameter int HALF_LEVELS = 16,
    parameter int K_SHIFT     = 2,
    localparam int LEV_SH     = $clog2(HALF_LEVELS),
    localparam int CODE_W     = LEV_SH + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [CODE_W-1:0] code_p,
    output logic signed [CODE_W-1:0] code_s
);
    import csd_pkg::*;

    localparam int STEP_SH = DATA_W - 1 - LEV_SH;
    localparam int ACC_W   = DATA_W + 2;
    localparam logic signed [31:0] DATA_MAX = (32'sd1 <<< (DATA_W - 1)) - 32'sd1;
    localparam logic signed [31:0] DATA_MIN = -(32'sd1 <<< (DATA_W - 1));

    logic signed [CODE_W-1:0] c1, c2, c1_d;
    logic signed [DATA_W-1:0] resid, resid_d;
    logic                     vld_d;

    csd_shaper #(
        .DATA_W(DATA_W), .ACC_W(ACC_W), .STEP_SH(STEP_SH),
        .HALF_LEVELS(HALF_LEVELS), .CODE_W(CODE_W)
    ) i_primary (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .x(in_data), .code(c1)
    );

    // Error extraction: gain the input-minus-code residue by K and saturate.
    always_comb begin
        resid = DATA_W'(clamp32((32'(in_data) - (32'(c1) <<< STEP_SH)) <<< K_SHIFT,
                                DATA_MIN, DATA_MAX));
    end

    // Stage boundary: hold the primary code and the gained residue for stage two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c1_d    <= '0;
            resid_d <= '0;
            vld_d   <= 1'b0;
        end else begin
            vld_d <= in_valid;
            if (in_valid) begin
                c1_d    <= c1;
                resid_d <= resid;
            end
        end
    end

    csd_shaper #(
        .DATA_W(DATA_W), .ACC_W(ACC_W), .STEP_SH(STEP_SH),
        .HALF_LEVELS(HALF_LEVELS), .CODE_W(CODE_W)
    ) i_secondary (
        .clk(clk), .rst_n(rst_n), .en(vld_d), .x(resid_d), .code(c2)
    );

    // Output register: publish both codes of the same sample together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_p    <= '0;
            code_s    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= vld_d;
            if (vld_d) begin
                code_p <= c1_d;
                code_s <= c2;
            end
        end
    end
endmodule

// File: rtl/csd_cascade_chk.sv
// Checker: temporal properties of the cascaded modulator ports.
// Assumes the default 6-bit code width, with limits taken from HALF_LEVELS.
module csd_cascade_chk #(
    parameter int HALF_LEVELS = 16,
    parameter int CODE_W      = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic signed [CODE_W-1:0] code_p,
    input logic signed [CODE_W-1:0] code_s
);
    // R1: a reset edge leaves the outputs idle and zero.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && code_p == '0 && code_s == '0));

    // R2: both codes stay within the 33-level range.
    assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(code_p) <= HALF_LEVELS && $signed(code_p) >= -HALF_LEVELS &&
         $signed(code_s) <= HALF_LEVELS && $signed(code_s) >= -HALF_LEVELS));

    // R6: each output strobe traces back to an accepted sample two edges earlier.
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R7: codes do not move on cycles without an output strobe.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> ($stable(code_p) && $stable(code_s)));
endmodule

bind csd_cascade csd_cascade_chk #(
    .HALF_LEVELS(HALF_LEVELS), .CODE_W(CODE_W)
) i_csd_cascade_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .code_p(code_p), .code_s(code_s)
);

// File: tb/test_csd_cascade.sv
// Scoreboard bench: the driver models each sample from the requirement
// equations and queues the expected codes; the monitor compares at the outputs.
module test_csd_cascade;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic              out_valid;
    logic signed [5:0] code_p, code_s;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct { int cp; int cs; int x; bit chk8; } exp_t;
    exp_t exp_q[$];

    int pqa = 0, pqb = 0, sqa = 0, sqb = 0;
    int last_p = 0, last_s = 0;
    bit have_last = 1'b0;

    csd_cascade i_csd_cascade (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .code_p(code_p), .code_s(code_s)
    );

    always #2.5 clk = ~clk;

    function automatic int lim(input int v, input int lo, input int hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    // R3 / R5 recursion for one loop.
    function automatic int loop_step(input int x, inout int qa, inout int qb);
        int v, c, q;
        v  = lim(x - 2 * qa + qb, -131071, 131071);
        c  = lim((v + 1024) >>> 11, -16, 16);
        q  = lim(c * 2048 - v, -4096, 4096);
        qb = qa;
        qa = q;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic drive(input int x, input bit chk8);
        exp_t e;
        int r;
        e.x    = x;
        e.chk8 = chk8;
        e.cp   = loop_step(x, pqa, pqb);
        r      = lim(4 * (x - e.cp * 2048), -32768, 32767);   // R4
        e.cs   = loop_step(r, sqa, sqb);
        exp_q.push_back(e);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = 16'(x);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare queued expectations, and check holding between strobes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    int comb;
                    e = exp_q.pop_front();
                    check(int'(code_p) == e.cp, "R3 primary code", int'(code_p), e.cp);
                    check(int'(code_s) == e.cs, "R5 secondary code", int'(code_s), e.cs);
                    check(int'(code_p) <= 16 && int'(code_p) >= -16, "R2 range", int'(code_p), e.cp);
                    if (e.chk8) begin
                        comb = 4 * (int'(code_p) * 2048 - e.x) + int'(code_s) * 2048;
                        check(comb <= 4096 && comb >= -4096, "R8 cancellation", comb, 0);
                    end
                end
                last_p = int'(code_p);
                last_s = int'(code_s);
                have_last = 1'b1;
            end else if (have_last) begin
                check(int'(code_p) == last_p && int'(code_s) == last_s,
                      "R7 hold", int'(code_p), last_p);
            end
        end
    end

    task automatic apply_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared while reset is held.
        check(!out_valid && code_p == 0 && code_s == 0, "R1 reset state",
              int'(code_p), 0);
        pqa = 0; pqb = 0; sqa = 0; sqb = 0;
        have_last = 1'b0;
        exp_q.delete();
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    initial begin
        apply_reset();
        // R1: after reset the loops start from zero state.
        for (int i = 0; i < 6; i++) drive(0, 1'b1);
        // DC between code steps.
        for (int i = 0; i < 40; i++) drive(1000, 1'b1);
        for (int i = 0; i < 40; i++) drive(-5000, 1'b1);
        // R7: gaps in the strobe.
        for (int i = 0; i < 30; i++) begin
            drive(3000 + 37 * i, 1'b1);
            if (i % 3 == 0) idle(2);
        end
        // R8: slow triangle sweep inside +/-24576.
        for (int i = 0; i < 400; i++) begin
            int t;
            t = (i % 140) * 350;
            t = (t < 24500) ? t : 49000 - t;
            drive(t - 12000, 1'b1);
        end
        // R2: full-scale extremes.
        for (int i = 0; i < 20; i++) drive(32767, 1'b0);
        for (int i = 0; i < 20; i++) drive(-32768, 1'b0);
        idle(4);
        // R1: mid-run reset clears the states.
        apply_reset();
        for (int i = 0; i < 20; i++) drive(2048, 1'b1);
        idle(6);
        check(exp_q.size() == 0, "R6 drained queue", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule